// File: doc/BRIEF.md
# SPI Flash Fast-Read Responder

This block acts as the target side of a serial flash read path. It watches chip select, serial clock and serial data in, and decodes one high-speed read command. That command is followed by a 24-bit start address and one byte of padding. After the padding the block streams bytes from an internal byte array on the serial output, most significant bit first, and steps the address after every byte. The address wraps to zero at the top of the array, so a single command can read the array without end. Raising chip select ends the transfer at any point.

All logic runs in one system clock domain. The serial clock, chip select, serial data and the busy flag each pass through a synchronizer, and serial clock edges are found by comparing successive synchronized samples. The serial clock must therefore stay high and low for several system clocks. The output pin's drive enable is a separate port, and the pad's high-impedance buffer sits outside the block. A backdoor write port fills the array while no transaction is open. The array holds 2^MEM_AW bytes: 1024 by default, and 17 address bits for a 1 Mbit part.

Top module: `sfr_fast_read`

## Requirements
- R1: After reset, and whenever chip select is high, `sdo_oe` is 0 (output high impedance). It falls within a few system clocks of chip select rising.
- R2: `sdo_oe` stays 0 through the first 40 serial clock rising edges of a transaction: 8 command, 24 address and 8 padding bits.
- R3: Input bits are sampled on serial clock rising edges, most significant bit first. Only command byte 0x0B starts a read. Any other value leaves `sdo_oe` at 0 until chip select next rises.
- R4: The 24-bit address arrives most significant bit first. Only its low MEM_AW bits select a byte, and all higher bits are ignored.
- R5: The first data bit is driven on the serial clock falling edge that follows the 40th rising edge. Data leaves most significant bit first and changes only after falling edges, never across a rising edge.
- R6: The byte address advances by one after each complete byte and wraps from 2^MEM_AW-1 to 0.
- R7: Chip select rising ends the transaction at any point, including partway through a data byte. The next transaction decodes a fresh command and address.
- R8: If `busy` is high when the command byte completes, the command is ignored and `sdo_oe` stays 0.
- R9: A backdoor write (`bd_we`=1) stores `bd_data` at `bd_addr` while chip select is high. A write attempted while chip select is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| busy | input | 1 | High while an erase, program or write cycle runs |
| bd_we | input | 1 | Backdoor write strobe |
| bd_addr | input | MEM_AW | Backdoor write address |
| bd_data | input | 8 | Backdoor write data |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Drive enable for the serial data out pad |

## Verification
A phase counter that is off by one moves every data byte by one bit. That shows up as a mismatch in the first byte read, one serial clock period after the padding. A wrong address shift or a wrong increment produces data from another location, either in the first byte or at the byte boundary where the wrap should happen. A missed reset on chip select, or a missed command rejection, shows up as `sdo_oe` rising when it should not, or as garbage in the next transaction's first byte.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam logic [7:0] FAST_RD_CMD = 8'h0B;
    localparam int CMD_BITS   = 8;
    localparam int ADDR_BITS  = 24;
    localparam int PAD_BITS   = 8;
    localparam int HDR_BITS   = CMD_BITS + ADDR_BITS + PAD_BITS;
    localparam int HDR_CW     = $clog2(HDR_BITS + 1);

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_PAD,
        PH_DATA,
        PH_IGNORE
    } phase_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic cs_hi;
        logic din;
        logic busy;
    } spi_evt_t;

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync
    import sfr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sck,
    input  logic     sdi,
    input  logic     busy,
    output spi_evt_t evt
);

    logic [STAGES-1:0] cs_q, sck_q, din_q, busy_q;
    logic              sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= '1;
            sck_q  <= '0;
            din_q  <= '0;
            busy_q <= '0;
            sck_d  <= 1'b0;
        end else begin
            cs_q   <= {cs_q[STAGES-2:0], cs_n};
            sck_q  <= {sck_q[STAGES-2:0], sck};
            din_q  <= {din_q[STAGES-2:0], sdi};
            busy_q <= {busy_q[STAGES-2:0], busy};
            sck_d  <= sck_q[STAGES-1];
        end
    end

    always_comb begin
        evt.rise  = sck_q[STAGES-1] & ~sck_d;
        evt.fall  = ~sck_q[STAGES-1] & sck_d;
        evt.cs_hi = cs_q[STAGES-1];
        evt.din   = din_q[STAGES-1];
        evt.busy  = busy_q[STAGES-1];
    end

endmodule

// File: rtl/sfr_mem.sv
module sfr_mem #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
    import sfr_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  spi_evt_t      evt,
    input  logic [7:0]    rd_data,
    output phase_t        phase,
    output logic [AW-1:0] rd_addr,
    output logic          sdo,
    output logic          sdo_oe
);

    logic [HDR_CW-1:0] cnt;
    logic [7:0]        cmd_sh;
    logic [7:0]        out_sh;
    logic [2:0]        obit;
    logic [7:0]        cur_byte;
    logic [7:0]        cmd_next;

    assign cur_byte = (obit == 3'd0) ? rd_data : out_sh;
    assign cmd_next = {cmd_sh[6:0], evt.din};

    always_ff @(posedge clk) begin
        if (rst || evt.cs_hi) begin
            phase   <= PH_CMD;
            cnt     <= '0;
            cmd_sh  <= '0;
            rd_addr <= '0;
            out_sh  <= '0;
            obit    <= '0;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
        end else begin
            if (evt.rise) begin
                unique case (phase)
                    PH_CMD: begin
                        cmd_sh <= cmd_next;
                        cnt    <= cnt + 1'b1;
                        if (cnt == HDR_CW'(CMD_BITS - 1))
                            phase <= (cmd_next == FAST_RD_CMD && !evt.busy) ? PH_ADDR : PH_IGNORE;
                    end
                    PH_ADDR: begin
                        rd_addr <= {rd_addr[AW-2:0], evt.din};
                        cnt     <= cnt + 1'b1;
                        if (cnt == HDR_CW'(CMD_BITS + ADDR_BITS - 1))
                            phase <= PH_PAD;
                    end
                    PH_PAD: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == HDR_CW'(HDR_BITS - 1))
                            phase <= PH_DATA;
                    end
                    default: ;
                endcase
            end
            if (evt.fall && phase == PH_DATA) begin
                sdo    <= cur_byte[7];
                out_sh <= {cur_byte[6:0], 1'b0};
                obit   <= obit + 1'b1;
                sdo_oe <= 1'b1;
                if (obit == 3'd7) rd_addr <= rd_addr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sfr_fast_read.sv
module sfr_fast_read
    import sfr_pkg::*;
#(
    parameter int MEM_AW      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              busy,
    input  logic              bd_we,
    input  logic [MEM_AW-1:0] bd_addr,
    input  logic [7:0]        bd_data,
    output logic              sdo,
    output logic              sdo_oe
);

    spi_evt_t          evt;
    phase_t            phase;
    logic [MEM_AW-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              mem_we;

    assign mem_we = bd_we & evt.cs_hi;

    sfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sck  (sck),
        .sdi  (sdi),
        .busy (busy),
        .evt  (evt)
    );

    sfr_mem #(.AW(MEM_AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (bd_addr),
        .wdata (bd_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    sfr_ctrl #(.AW(MEM_AW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_data (rd_data),
        .phase   (phase),
        .rd_addr (rd_addr),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

endmodule

// File: rtl/sfr_chk.sv
module sfr_chk
    import sfr_pkg::*;
#(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input spi_evt_t      evt,
    input phase_t        phase,
    input logic [AW-1:0] rd_addr,
    input logic          sdo,
    input logic          sdo_oe
);

    AST_OE_DROPS_ON_CS: assert property (@(posedge clk) disable iff (rst)
        evt.cs_hi |=> !sdo_oe);                                              // R1

    AST_OE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> phase == PH_DATA);                                        // R2

    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (rst)
        phase == PH_IGNORE |-> !sdo_oe);                                     // R3

    AST_SDO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!evt.fall && !evt.cs_hi) |=> $stable(sdo));                         // R5

    AST_ADDR_HOLDS_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && !evt.fall && !evt.cs_hi) |=> $stable(rd_addr)); // R6

    AST_CS_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        evt.cs_hi |=> phase == PH_CMD);                                      // R7

endmodule

bind sfr_fast_read sfr_chk #(.AW(MEM_AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .phase   (phase),
    .rd_addr (rd_addr),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
);

// File: tb/sfr_fast_read_tb.sv
module sfr_fast_read_tb;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          sdi = 1'b0;
    logic          busy = 1'b0;
    logic          bd_we = 1'b0;
    logic [AW-1:0] bd_addr = '0;
    logic [7:0]    bd_data = '0;
    logic          sdo;
    logic          sdo_oe;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  hdr_bad;
    logic [7:0] model [DEPTH];

    // cmd[40:33] addr[32:9] nbytes[8:1] busy[0]
    localparam logic [40:0] VEC [0:5] = '{
        {8'h0B, 24'h000000, 8'd3, 1'b0},
        {8'h0B, 24'h0001F3, 8'd2, 1'b0},
        {8'h0B, 24'hFEA005, 8'd2, 1'b0},
        {8'h03, 24'h000010, 8'd2, 1'b0},
        {8'h0B, 24'h000020, 8'd2, 1'b1},
        {8'h0B, 24'h0003FE, 8'd4, 1'b0}
    };

    sfr_fast_read #(.MEM_AW(AW)) u_dut (
        .clk (clk), .rst (rst), .cs_n (cs_n), .sck (sck), .sdi (sdi),
        .busy (busy), .bd_we (bd_we), .bd_addr (bd_addr), .bd_data (bd_data),
        .sdo (sdo), .sdo_oe (sdo_oe)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sdi = b[i];
            wait_clk(HALF);
            if (sdo_oe) hdr_bad = 1;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic read_bytes(input int n, input int start, input bit expect_on, input string req);
        for (int j = 0; j < n; j++) begin
            logic [7:0] got;
            bit oe_all, oe_any, unstable;
            logic s0;
            got = '0; oe_all = 1; oe_any = 0; unstable = 0;
            for (int k = 7; k >= 0; k--) begin
                wait_clk(HALF);
                s0 = sdo;
                got[k] = sdo;
                oe_all &= sdo_oe;
                oe_any |= sdo_oe;
                sck = 1'b1;
                wait_clk(HALF / 2);
                if (sdo !== s0) unstable = 1;
                wait_clk(HALF - HALF / 2);
                sck = 1'b0;
            end
            if (expect_on) begin
                check(oe_all, req, int'(oe_all), 1);
                check(got == model[(start + j) % DEPTH], req, int'(got),
                      int'(model[(start + j) % DEPTH]));
                check(!unstable, "R5", int'(unstable), 0);
            end else begin
                check(!oe_any, req, int'(oe_any), 0);
            end
        end
    endtask

    task automatic cs_open();
        cs_n = 1'b0;
        hdr_bad = 0;
        wait_clk(HALF);
    endtask

    task automatic cs_close();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic send_header(input logic [7:0] cmd, input logic [23:0] addr);
        send_byte(cmd);
        send_byte(addr[23:16]);
        send_byte(addr[15:8]);
        send_byte(addr[7:0]);
        send_byte(8'hA5);
        check(!hdr_bad, "R2", int'(hdr_bad), 0);
    endtask

    task automatic txn(input logic [7:0] cmd, input logic [23:0] addr, input int n,
                       input bit bsy, input string req);
        busy = bsy;
        cs_open();
        send_header(cmd, addr);
        read_bytes(n, int'(addr) % DEPTH, (cmd == 8'h0B) && !bsy, req);
        cs_close();
        busy = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        check(sdo_oe == 1'b0, "R1", int'(sdo_oe), 0);

        // preload through the backdoor with chip select high (R9)
        for (int a = 0; a < DEPTH; a++) begin
            model[a] = pattern(a);
            bd_we = 1'b1; bd_addr = AW'(a); bd_data = model[a];
            wait_clk(1);
        end
        bd_we = 1'b0;
        wait_clk(4);

        // table of transactions: R3 R4 R5 R6 R8
        for (int v = 0; v < 6; v++) begin
            string req;
            req = (v == 2) ? "R4" : (v == 3) ? "R3" : (v == 4) ? "R8" : (v == 5) ? "R6" : "R5";
            txn(VEC[v][40:33], VEC[v][32:9], int'(VEC[v][8:1]), VEC[v][0], req);
        end

        // R7: abort partway through the second byte
        cs_open();
        send_header(8'h0B, 24'h000100);
        for (int k = 0; k < 11; k++) begin
            wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
        end
        wait_clk(2);
        cs_n = 1'b1;
        wait_clk(6);
        check(sdo_oe == 1'b0, "R7", int'(sdo_oe), 0);
        check(sdo_oe == 1'b0, "R1", int'(sdo_oe), 0);
        wait_clk(HALF);
        txn(8'h0B, 24'h000200, 2, 1'b0, "R7");

        // R9: backdoor write with chip select low is dropped
        cs_n = 1'b0;
        wait_clk(HALF);
        bd_we = 1'b1; bd_addr = AW'(5); bd_data = ~model[5];
        wait_clk(1);
        bd_we = 1'b0;
        cs_n = 1'b1;
        wait_clk(HALF);
        txn(8'h0B, 24'h000005, 1, 1'b0, "R9");

        // R9: backdoor write with chip select high lands
        bd_we = 1'b1; bd_addr = AW'(6); bd_data = 8'h5A;
        wait_clk(1);
        bd_we = 1'b0;
        model[6] = 8'h5A;
        wait_clk(2);
        txn(8'h0B, 24'h000006, 1, 1'b0, "R9");

        // R3: a rejected command stays silent after extra clocks
        txn(8'hFF, 24'h000000, 2, 1'b0, "R3");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule